// File: doc/BRIEF.md
# Multiplexed Burst Bus Slave Bridge

This block is the target side of a synchronous host bus that shares sixteen pins between address and data. A host frames each access with an active-low select. It first presents a 19-bit address: the low sixteen bits go on the shared pins and the top three go on dedicated pins, qualified by an active-low address strobe. It then moves one 32-bit word as two 16-bit beats, low half first. The bridge turns every complete access into a single request on a simple internal register port, which has an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data returned with a ready pulse.

All bus inputs, including the bus clock itself, are sampled by the bridge's own faster system clock through a synchronizer of parameterized depth. Bus-clock edges are recognised from the synchronized copy. On reads the bridge pulls its active-low wait output low until the internal data has come back. It releases wait only on a bus-clock falling edge, so the host sees a clean change before its next rising edge. The bridge drives the shared pins only during the data part of a read, while both select and output enable are low. If select is released partway through an access, the bridge drops the access and returns to idle.

Top module: `muxbus_slave`

## Requirements
- R1: After reset, and whenever idle, `bus_wait_n` is 1, `reg_wr` and `reg_rd` are 0, and the shared pins are not driven.
- R2: On the first bus-clock rising edge with select and address strobe both low, the bridge captures the address as {`bus_ahi`, `bus_ad`} and presents it on `reg_addr` for the internal access.
- R3: In a write (write strobe low at the address edge), the next rising edge carries data bits 15:0 and the one after it carries bits 31:16; `reg_wdata` holds the assembled word.
- R4: Each completed write gives exactly one `reg_wr` pulse, one system clock wide, issued only after both halves have been captured.
- R5: In a read, the bridge issues one single-cycle `reg_rd` pulse after the address edge and holds `bus_wait_n` low from that pulse until `reg_rdy` has returned the data. It then raises `bus_wait_n` after a bus-clock falling edge.
- R6: After wait goes high, RD_LEAD_EDGES rising edges pass (default 1). The next rising edge samples data bits 15:0, and the rising edge after that samples bits 31:16.
- R7: The shared pins are driven only in the data part of a read while select and output enable are low. They are released no more than SYNC_STAGES+1 system cycles after output enable goes high.
- R8: If select goes high before the second write beat, the access is dropped: no `reg_wr` is issued and the target register keeps its value.
- R9: `bus_wait_n` stays high for the whole of a write.
- R10: A read may follow a write with no idle bus cycles between them and returns the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_clk | input | 1 | Bus clock from the host |
| bus_cs_n | input | 1 | Active-low select framing one access |
| bus_adv_n | input | 1 | Active-low address strobe |
| bus_we_n | input | 1 | Active-low write marker |
| bus_oe_n | input | 1 | Active-low output enable for reads |
| bus_ahi | input | HI_W | Address bits above the shared pins |
| bus_ad | inout | HALF_W | Shared address/data pins |
| bus_wait_n | output | 1 | Active-low wait to the host |
| reg_addr | output | HI_W+HALF_W | Internal register address |
| reg_wdata | output | 2*HALF_W | Internal write data |
| reg_wr | output | 1 | Internal write strobe, one cycle |
| reg_rd | output | 1 | Internal read strobe, one cycle |
| reg_rdata | input | 2*HALF_W | Internal read data |
| reg_rdy | input | 1 | Internal read data valid |

## Verification
Each bus event reaches the internal side SYNC_STAGES+1 system cycles after the pin change: about three cycles at the default depth. The bench therefore holds every bus half period for eight system cycles and changes pins only on falling system-clock edges, so every result has settled before the next bus edge. The write strobe is compared by a monitor on the system cycle in which it appears. Read data is sampled at the host's rising edge, before the bridge can react to that same edge. Pin release and the wait level are checked one full bus half period or more after the stimulus, which leaves a clear margin over the synchronizer latency.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WR_LO,
      ST_WR_HI,
      ST_WR_END,
      ST_RD_WAIT,
      ST_RD_LO,
      ST_RD_HI
   } mb_state_e;
endpackage

// File: rtl/mb_sync.sv
module mb_sync #(
   parameter int          W       = 1,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mb_pad.sv
module mb_pad #(
   parameter int W = 16
) (
   inout  wire  [W-1:0] pad,
   input  logic         oe,
   input  logic [W-1:0] dout,
   output logic [W-1:0] din
);
   assign pad = oe ? dout : {W{1'bz}};
   assign din = pad;
endmodule

// File: rtl/mb_ctrl.sv
module mb_ctrl
   import muxbus_pkg::*;
#(
   parameter int HALF_W        = 16,
   parameter int HI_W          = 3,
   parameter int RD_LEAD_EDGES = 1,
   localparam int ADDR_W = HI_W + HALF_W,
   localparam int WORD_W = 2 * HALF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_s,
   input  logic              cs_n_s,
   input  logic              adv_n_s,
   input  logic              we_n_s,
   input  logic              oe_n_s,
   input  logic [HI_W-1:0]   ahi_s,
   input  logic [HALF_W-1:0] ad_s,
   input  logic              reg_rdy,
   input  logic [WORD_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [WORD_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic              wait_n,
   output logic              pad_oe,
   output logic [HALF_W-1:0] pad_dout
);
   localparam int CNT_W = (RD_LEAD_EDGES < 1) ? 1 : $clog2(RD_LEAD_EDGES + 1);

   mb_state_e         state;
   logic              bclk_d;
   logic              rise;
   logic              fall;
   logic              have_data;
   logic [CNT_W-1:0]  lead_cnt;
   logic [WORD_W-1:0] rdata_q;
   logic              rd_phase;

   assign rise     = bclk_s & ~bclk_d;
   assign fall     = ~bclk_s & bclk_d;
   assign rd_phase = (state == ST_RD_WAIT) || (state == ST_RD_LO) || (state == ST_RD_HI);
   assign pad_dout = (state == ST_RD_HI) ? rdata_q[WORD_W-1:HALF_W] : rdata_q[HALF_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_d <= 1'b0;
         pad_oe <= 1'b0;
      end else begin
         bclk_d <= bclk_s;
         pad_oe <= rd_phase & ~cs_n_s & ~oe_n_s;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         wait_n    <= 1'b1;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         rdata_q   <= '0;
         have_data <= 1'b0;
         lead_cnt  <= '0;
      end else begin
         reg_wr <= 1'b0;
         reg_rd <= 1'b0;
         if (cs_n_s) begin
            state     <= ST_IDLE;
            wait_n    <= 1'b1;
            have_data <= 1'b0;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (rise && !adv_n_s) begin
                     reg_addr <= {ahi_s, ad_s};
                     if (!we_n_s) begin
                        state <= ST_WR_LO;
                     end else begin
                        state     <= ST_RD_WAIT;
                        reg_rd    <= 1'b1;
                        wait_n    <= 1'b0;
                        have_data <= 1'b0;
                     end
                  end
               end
               ST_WR_LO: begin
                  if (rise) begin
                     reg_wdata[HALF_W-1:0] <= ad_s;
                     state                 <= ST_WR_HI;
                  end
               end
               ST_WR_HI: begin
                  if (rise) begin
                     reg_wdata[WORD_W-1:HALF_W] <= ad_s;
                     reg_wr                     <= 1'b1;
                     state                      <= ST_WR_END;
                  end
               end
               ST_RD_WAIT: begin
                  if (reg_rdy && !have_data) begin
                     rdata_q   <= reg_rdata;
                     have_data <= 1'b1;
                  end
                  if (have_data && fall) begin
                     wait_n   <= 1'b1;
                     lead_cnt <= '0;
                     state    <= ST_RD_LO;
                  end
               end
               ST_RD_LO: begin
                  if (rise) begin
                     if (lead_cnt == CNT_W'(RD_LEAD_EDGES)) state <= ST_RD_HI;
                     else lead_cnt <= lead_cnt + CNT_W'(1);
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave #(
   parameter int HALF_W        = 16,
   parameter int HI_W          = 3,
   parameter int SYNC_STAGES   = 2,
   parameter int RD_LEAD_EDGES = 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_clk,
   input  logic                   bus_cs_n,
   input  logic                   bus_adv_n,
   input  logic                   bus_we_n,
   input  logic                   bus_oe_n,
   input  logic [HI_W-1:0]        bus_ahi,
   inout  wire  [HALF_W-1:0]      bus_ad,
   output logic                   bus_wait_n,
   output logic [HI_W+HALF_W-1:0] reg_addr,
   output logic [2*HALF_W-1:0]    reg_wdata,
   output logic                   reg_wr,
   output logic                   reg_rd,
   input  logic [2*HALF_W-1:0]    reg_rdata,
   input  logic                   reg_rdy
);
   localparam int ADDR_W = HI_W + HALF_W;
   localparam int CTL_W  = 5;

   if (HALF_W < 8) begin : g_bad_half
      $error("HALF_W must be at least 8");
   end
   if (HI_W < 1) begin : g_bad_hi
      $error("HI_W must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RD_LEAD_EDGES < 0) begin : g_bad_lead
      $error("RD_LEAD_EDGES must not be negative");
   end

   logic [CTL_W-1:0]  ctl_s;
   logic [ADDR_W-1:0] dat_s;
   logic [HALF_W-1:0] pad_din;
   logic [HALF_W-1:0] pad_dout;
   logic              pad_oe;

   mb_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b01111)) u_sync_ctl (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_clk, bus_cs_n, bus_adv_n, bus_we_n, bus_oe_n}),
      .q     (ctl_s)
   );

   mb_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_ahi, pad_din}),
      .q     (dat_s)
   );

   mb_pad #(.W(HALF_W)) u_pad (
      .pad  (bus_ad),
      .oe   (pad_oe),
      .dout (pad_dout),
      .din  (pad_din)
   );

   mb_ctrl #(.HALF_W(HALF_W), .HI_W(HI_W), .RD_LEAD_EDGES(RD_LEAD_EDGES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_s    (ctl_s[4]),
      .cs_n_s    (ctl_s[3]),
      .adv_n_s   (ctl_s[2]),
      .we_n_s    (ctl_s[1]),
      .oe_n_s    (ctl_s[0]),
      .ahi_s     (dat_s[ADDR_W-1:HALF_W]),
      .ad_s      (dat_s[HALF_W-1:0]),
      .reg_rdy   (reg_rdy),
      .reg_rdata (reg_rdata),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .wait_n    (bus_wait_n),
      .pad_oe    (pad_oe),
      .pad_dout  (pad_dout)
   );
endmodule

// File: rtl/muxbus_slave_chk.sv
module muxbus_slave_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic bus_oe_n,
   input logic bus_wait_n,
   input logic reg_wr,
   input logic reg_rd,
   input logic reg_rdy,
   input logic pad_oe
);
   localparam int LIM   = SYNC_STAGES + 2;
   localparam int CNT_W = $clog2(LIM + 1);

   logic [CNT_W-1:0] oe_hi_cnt;
   logic             rd_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_hi_cnt <= '0;
         rd_pend   <= 1'b0;
      end else begin
         if (!bus_oe_n)                       oe_hi_cnt <= '0;
         else if (oe_hi_cnt != CNT_W'(LIM))   oe_hi_cnt <= oe_hi_cnt + CNT_W'(1);
         rd_pend <= (rd_pend | reg_rd) & ~reg_rdy;
      end
   end

   assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);

   assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);

   assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

   assert_rd_holds_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> !bus_wait_n);

   assert_wait_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_wait_n) |-> !rd_pend);

   assert_pins_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_hi_cnt == CNT_W'(LIM)) |-> !pad_oe);

   assert_write_no_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |-> bus_wait_n);
endmodule

bind muxbus_slave muxbus_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_oe_n   (bus_oe_n),
   .bus_wait_n (bus_wait_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_rdy    (reg_rdy),
   .pad_oe     (pad_oe)
);

// File: tb/muxbus_slave_test.sv
`timescale 1ns/1ps
module muxbus_slave_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0;
   logic        cs_n = 1'b1;
   logic        adv_n = 1'b1;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic [2:0]  ahi = 3'd0;
   logic [15:0] ad_out = 16'd0;
   logic        ad_drv = 1'b0;
   tri1  [15:0] bus_ad;
   logic        bus_wait_n;
   logic [18:0] reg_addr;
   logic [31:0] reg_wdata;
   logic        reg_wr;
   logic        reg_rd;
   logic [31:0] reg_rdata = 32'd0;
   logic        reg_rdy = 1'b0;

   assign bus_ad = ad_drv ? ad_out : 16'bz;

   always #2.5 clk = ~clk;

   muxbus_slave uut (
      .clk(clk), .rst_n(rst_n), .bus_clk(bclk), .bus_cs_n(cs_n), .bus_adv_n(adv_n),
      .bus_we_n(we_n), .bus_oe_n(oe_n), .bus_ahi(ahi), .bus_ad(bus_ad),
      .bus_wait_n(bus_wait_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_rdy(reg_rdy)
   );

   int n_chk = 0;
   int n_fail = 0;
   int wr_seen = 0;
   int rd_seen = 0;
   int n_wr_exp = 0;
   int n_rd_exp = 0;
   int rd_lat = 0;
   int lat_cnt = -1;
   bit finished = 1'b0;
   logic [18:0] last_rd_addr = 19'd0;
   logic [31:0] regs [16];
   logic [31:0] model [16];
   logic [50:0] wq [$];
   logic        prev_wr = 1'b0;

   function automatic logic [31:0] init_val(input int i);
      return 32'hC0DE_0000 | (32'(i) * 32'h0000_0101);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] want);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, want);
      end
   endtask

   // internal register file and write monitor (scoreboard side)
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 16; i++) regs[i] = init_val(i);
         prev_wr = 1'b0;
      end else begin
         if (reg_wr) begin
            wr_seen++;
            chk(!prev_wr, "R4 write strobe one cycle", 32'(prev_wr), 32'd0);
            if (wq.size() == 0) begin
               chk(1'b0, "R8 unexpected internal write", 32'(reg_addr), 32'd0);
            end else begin
               logic [50:0] item;
               item = wq.pop_front();
               chk(reg_addr == item[50:32], "R2 write address", 32'(reg_addr), 32'(item[50:32]));
               chk(reg_wdata == item[31:0], "R3 write data", reg_wdata, item[31:0]);
            end
            regs[reg_addr[3:0]] = reg_wdata;
         end
         prev_wr = reg_wr;
      end
   end

   // internal read responder
   always @(negedge clk) begin
      reg_rdy = 1'b0;
      if (rst_n) begin
         if (reg_rd) begin
            rd_seen++;
            last_rd_addr = reg_addr;
            lat_cnt = rd_lat;
         end
         if (lat_cnt == 0) begin
            reg_rdy = 1'b1;
            reg_rdata = regs[reg_addr[3:0]];
            lat_cnt = -1;
         end else if (lat_cnt > 0) begin
            lat_cnt--;
         end
      end
   end

   task automatic bus_write(input logic [18:0] addr, input logic [31:0] data, input bit abort);
      if (!abort) begin
         wq.push_back({addr, data});
         model[addr[3:0]] = data;
         n_wr_exp++;
      end
      cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b0;
      ad_drv = 1'b1; ad_out = addr[15:0]; ahi = addr[18:16];
      #40 bclk = 1'b1;
      #40 bclk = 1'b0; adv_n = 1'b1; ad_out = data[15:0];
      #40 bclk = 1'b1;
      if (abort) begin
         #40 bclk = 1'b0; cs_n = 1'b1; we_n = 1'b1; ad_drv = 1'b0;
         #160;
         return;
      end
      #40 bclk = 1'b0; ad_out = data[31:16];
      #40 bclk = 1'b1;
      #40 bclk = 1'b0; ad_drv = 1'b0;
      #40;
      chk(bus_wait_n == 1'b1, "R9 wait high during write", 32'(bus_wait_n), 32'd1);
      cs_n = 1'b1; we_n = 1'b1;
      #80;
   endtask

   task automatic bus_read(input logic [18:0] addr, input int lat, output logic [31:0] data, output int wedges);
      rd_lat = lat;
      n_rd_exp++;
      wedges = 0;
      cs_n = 1'b0; adv_n = 1'b0; we_n = 1'b1;
      ad_drv = 1'b1; ad_out = addr[15:0]; ahi = addr[18:16];
      #40 bclk = 1'b1;
      #40 bclk = 1'b0; adv_n = 1'b1; ad_drv = 1'b0; oe_n = 1'b0;
      #40;
      while (bus_wait_n == 1'b0) begin
         bclk = 1'b1;
         #40 bclk = 1'b0;
         wedges++;
         #40;
      end
      bclk = 1'b1;
      #40 bclk = 1'b0;
      #40 bclk = 1'b1; data[15:0] = bus_ad;
      #40 bclk = 1'b0;
      #40 bclk = 1'b1; data[31:16] = bus_ad;
      #40 bclk = 1'b0;
      #40 cs_n = 1'b1; oe_n = 1'b1;
      #80;
      chk(bus_ad == 16'hFFFF, "R7 pins released after read", 32'(bus_ad), 32'h0000_FFFF);
      chk(last_rd_addr == addr, "R2 read address", 32'(last_rd_addr), 32'(addr));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] got;
      int          we;
      int          wr_before;
      for (int i = 0; i < 16; i++) model[i] = init_val(i);
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset/idle state
      chk(bus_wait_n == 1'b1, "R1 wait high at reset", 32'(bus_wait_n), 32'd1);
      chk(reg_wr == 1'b0, "R1 no write strobe at reset", 32'(reg_wr), 32'd0);
      chk(reg_rd == 1'b0, "R1 no read strobe at reset", 32'(reg_rd), 32'd0);
      chk(bus_ad == 16'hFFFF, "R1 pins released at reset", 32'(bus_ad), 32'h0000_FFFF);

      // R2 R3 R4 R9 writes with varied address high bits and halves
      bus_write(19'h7_0003, 32'hA5A5_3C3C, 1'b0);
      bus_write(19'h2_1001, 32'h1234_FEDC, 1'b0);
      bus_write(19'h5_000F, 32'h8001_7FFE, 1'b0);
      chk(wr_seen == 3, "R4 one strobe per write", 32'(wr_seen), 32'd3);

      // R5 R6 reads with different internal latencies
      bus_read(19'h7_0003, 0, got, we);
      chk(got == model[3], "R6 read data latency 0", got, model[3]);
      bus_read(19'h2_1001, 3, got, we);
      chk(got == model[1], "R6 read data latency 3", got, model[1]);
      bus_read(19'h5_000F, 60, got, we);
      chk(got == model[15], "R6 read data latency 60", got, model[15]);
      chk(we >= 1, "R5 wait held during slow read", 32'(we), 32'd1);
      bus_read(19'h0_0007, 1, got, we);
      chk(got == model[7], "R6 read of unwritten register", got, model[7]);
      chk(bus_wait_n == 1'b1, "R1 wait high when idle", 32'(bus_wait_n), 32'd1);

      // R8 aborted write leaves register untouched
      wr_before = wr_seen;
      bus_write(19'h1_0003, 32'hDEAD_BEEF, 1'b1);
      chk(wr_seen == wr_before, "R8 no strobe on abort", 32'(wr_seen), 32'(wr_before));
      bus_read(19'h1_0003, 2, got, we);
      chk(got == model[3], "R8 register kept after abort", got, model[3]);

      // R10 back-to-back write then read
      bus_write(19'h3_0008, 32'h55AA_0FF0, 1'b0);
      bus_read(19'h3_0008, 2, got, we);
      chk(got == 32'h55AA_0FF0, "R10 read after write", got, 32'h55AA_0FF0);

      repeat (20) @(negedge clk);
      chk(wq.size() == 0, "R4 all writes issued", 32'(wq.size()), 32'd0);
      chk(wr_seen == n_wr_exp, "R4 write strobe count", 32'(wr_seen), 32'(n_wr_exp));
      chk(rd_seen == n_rd_exp, "R5 read strobe count", 32'(rd_seen), 32'(n_rd_exp));

      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule